// File: doc/BRIEF.md
# Parallel ADC Readout Controller

This block runs an external 16-bit sampling converter with a parallel output bus from the system clock. It raises a conversion-start pulse, either on a one-cycle request or at a fixed sample period while periodic mode is enabled. It then finds the end of conversion in one of two ways. It can watch the converter's ready line, which is high when the converter is idle and low while it converts. It can also wait a fixed 6.5 us counted from the start pulse.

Once a result is available, the block reads it with an active-low chip select and an active-low read strobe. It can fetch all 16 bits in one access. It can also fetch them as two byte accesses on the low eight data lines, with a byte-select line choosing the upper byte first and the lower byte second. The assembled word is presented with a one-cycle valid pulse.

Every nanosecond figure in the timing rules is a parameter. Each is turned into a cycle count at elaboration, rounded up. With the defaults (5 ns clock) the counts are:

| Interval | Cycles |
|---|---|
| Start pulse | 10 |
| Read strobe low | 12 |
| Byte-select setup | 16 |
| Byte-select hold | 5 |
| Fixed wait | 1300 |
| Ready timeout | 2000 |
| Sample period | 1600 |

Top module: `adc_readout_ctrl`

## Requirements
- R1: After synchronous reset, `adc_convst` is 0, `adc_cs_n` and `adc_rd_n` are 1, `adc_hben` is 0, and `sample_valid` and `timeout_err` are 0.
- R2: Each conversion starts with `adc_convst` high for exactly 10 cycles, and chip select is never low while it is high.
- R3: With `use_busy`=1, chip select falls exactly 3 cycles after `adc_ready` is first seen high following a start (two synchroniser stages plus the decision register).
- R4: With `use_busy`=0, chip select falls exactly 1300 cycles after `adc_convst` rose, whatever `adc_ready` does.
- R5: Each read strobe stays low exactly 12 cycles, with chip select low for the whole strobe. The bus is captured on the edge that ends the strobe.
- R6: With `byte_mode`=1, one chip-select window holds two strobes. The first has `adc_hben`=1 and takes bits 15:8 from `adc_data[7:0]`. The second has `adc_hben`=0 and takes bits 7:0 from `adc_data[7:0]`. `adc_hben` is settled at least 16 cycles before each strobe falls and held at least 5 cycles after it rises.
- R7: With `byte_mode`=0, one chip-select window holds one strobe with `adc_hben`=0, and `adc_data[15:0]` is the sample.
- R8: `sample_valid` is a one-cycle pulse, 15 cycles (word) or 67 cycles (byte) after chip select falls. `sample` then equals the converted value.
- R9: While `run_en` is high, consecutive starts are exactly 1600 cycles apart. The period is never below the 6025 ns throughput limit.
- R10: `trig` starts a conversion only when the block is idle; a request during a conversion or read is ignored.
- R11: With `use_busy`=1, if ready is not seen high by cycle 2000 after the start, `timeout_err` pulses for one cycle exactly 2000 cycles after the start. The block then returns to idle with no read and no valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | One-shot conversion request |
| run_en | input | 1 | Periodic conversion enable |
| byte_mode | input | 1 | 1: two byte reads, 0: one word read |
| use_busy | input | 1 | 1: wait on ready line, 0: fixed wait |
| adc_ready | input | 1 | Converter ready, low while converting |
| adc_data | input | 16 | Converter data bus |
| adc_convst | output | 1 | Conversion start pulse |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_hben | output | 1 | Upper byte select |
| sample | output | 16 | Assembled sample |
| sample_valid | output | 1 | One-cycle sample strobe |
| timeout_err | output | 1 | One-cycle ready timeout flag |

## Verification
The bench's converter model drives garbage on the bus until 11 cycles into a strobe. A controller that captured the bus a cycle early would therefore return the filler pattern instead of the sample.

The first samples are 8000, 7FFF, 00FF and FF00 (hex), so a swapped or duplicated byte order changes the assembled word.

The bench also targets the following corner cases:
- It measures each byte-select setup and hold against the strobe edges; cutting the turnaround between byte reads would break these.
- It times the read start against the ready edge, exposing a missing synchroniser.
- It pulses the request mid-conversion to catch a second start.
- It freezes the converter to show that a missing timeout hangs the block.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
  typedef enum logic [1:0] {C_IDLE, C_START, C_WAIT, C_READ} ctl_state_t;
  typedef enum logic [1:0] {Q_IDLE, Q_SETUP, Q_STROBE, Q_HOLD} rd_state_t;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_pace.sv
`timescale 1ns/1ps
module adc_pace #(
  parameter int PERIOD_CYC = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic started,
  input  logic run_en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD_CYC + 1);

  logic [CW-1:0] since;

  // Counts cycles since the last start, saturating at the period.
  always_ff @(posedge clk) begin
    if (rst)
      since <= CW'(PERIOD_CYC);
    else if (started)
      since <= CW'(1);
    else if (since < CW'(PERIOD_CYC))
      since <= since + 1'b1;
  end

  assign tick = run_en && (since == CW'(PERIOD_CYC));
endmodule

// File: rtl/adc_rd_seq.sv
`timescale 1ns/1ps
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RD_CYC = 12,
  parameter int SU_CYC = 16,
  parameter int HD_CYC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] bus,
  output logic              cs_n,
  output logic              rd_n,
  output logic              hben,
  output logic [DATA_W-1:0] word,
  output logic              done
);
  localparam int HW = DATA_W / 2;
  localparam int CW = $clog2(imax(imax(RD_CYC, SU_CYC), HD_CYC) + 1);

  rd_state_t     st;
  logic [CW-1:0] cnt;
  logic          byte_q;
  logic          lower;
  logic [CW-1:0] su_len;
  logic [CW-1:0] hd_len;

  assign su_len = byte_q ? CW'(SU_CYC) : CW'(1);
  assign hd_len = byte_q ? CW'(HD_CYC) : CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= Q_IDLE;
      cnt    <= '0;
      cs_n   <= 1'b1;
      rd_n   <= 1'b1;
      hben   <= 1'b0;
      word   <= '0;
      done   <= 1'b0;
      byte_q <= 1'b0;
      lower  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        Q_IDLE: if (go) begin
          cs_n   <= 1'b0;
          hben   <= byte_mode;
          byte_q <= byte_mode;
          lower  <= 1'b0;
          cnt    <= CW'(1);
          st     <= Q_SETUP;
        end
        Q_SETUP: if (cnt == su_len) begin
          rd_n <= 1'b0;
          cnt  <= CW'(1);
          st   <= Q_STROBE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        Q_STROBE: if (cnt == CW'(RD_CYC)) begin
          rd_n <= 1'b1;
          if (!byte_q)
            word <= bus;
          else if (!lower)
            word[DATA_W-1:HW] <= bus[HW-1:0];
          else
            word[HW-1:0] <= bus[HW-1:0];
          cnt <= CW'(1);
          st  <= Q_HOLD;
        end else begin
          cnt <= cnt + 1'b1;
        end
        Q_HOLD: if (cnt == hd_len) begin
          if (byte_q && !lower) begin
            hben  <= 1'b0;
            lower <= 1'b1;
            cnt   <= CW'(1);
            st    <= Q_SETUP;
          end else begin
            cs_n <= 1'b1;
            hben <= 1'b0;
            done <= 1'b1;
            st   <= Q_IDLE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

  // R5
  rd_in_cs_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !cs_n);
  // R5
  rd_min_chk: assert property (@(posedge clk) disable iff (rst) $fell(rd_n) |=> !rd_n);
  // R6
  hben_stable_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> $stable(hben));
endmodule

// File: rtl/adc_readout_ctrl.sv
`timescale 1ns/1ps
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int CLK_NS        = 5,
  parameter int CONVST_NS     = 50,
  parameter int BUSY_LAT_NS   = 100,
  parameter int RD_LOW_NS     = 60,
  parameter int ACCESS_NS     = 57,
  parameter int RELEASE_NS    = 50,
  parameter int HB_SETUP_NS   = 80,
  parameter int HB_HOLD_NS    = 25,
  parameter int FIXED_WAIT_NS = 6500,
  parameter int TIMEOUT_NS    = 10000,
  parameter int SAMPLE_NS     = 8000,
  parameter int MIN_PERIOD_NS = 6025
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic              run_en,
  input  logic              byte_mode,
  input  logic              use_busy,
  input  logic              adc_ready,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_convst,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic              adc_hben,
  output logic [DATA_W-1:0] sample,
  output logic              sample_valid,
  output logic              timeout_err
);
  localparam int START_CYC   = imax(2, ns2cyc(CONVST_NS, CLK_NS));
  localparam int LAT_CYC     = ns2cyc(BUSY_LAT_NS, CLK_NS);
  localparam int WAIT_MIN    = imax(START_CYC, LAT_CYC) + 2;
  localparam int RD_CYC      = ns2cyc(imax(RD_LOW_NS, ACCESS_NS), CLK_NS);
  localparam int SU_CYC      = ns2cyc(imax(HB_SETUP_NS, RELEASE_NS), CLK_NS);
  localparam int HD_CYC      = imax(1, ns2cyc(HB_HOLD_NS, CLK_NS));
  localparam int FIXED_CYC   = imax(WAIT_MIN, ns2cyc(FIXED_WAIT_NS, CLK_NS));
  localparam int TIMEOUT_CYC = imax(WAIT_MIN + 1, ns2cyc(TIMEOUT_NS, CLK_NS));
  localparam int PERIOD_CYC  = imax(ns2cyc(SAMPLE_NS, CLK_NS), ns2cyc(MIN_PERIOD_NS, CLK_NS));
  localparam int TW          = $clog2(imax(FIXED_CYC, TIMEOUT_CYC) + 2);

  ctl_state_t        state;
  logic [TW-1:0]     tmr;
  logic              busy_m;
  logic              rdy_s1, rdy_s2;
  logic              tick;
  logic              go_conv;
  logic              rd_go;
  logic              to_hit;
  logic              seq_done;
  logic [DATA_W-1:0] seq_word;

  // Two-stage synchroniser on the asynchronous ready line.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_s1 <= 1'b0;
      rdy_s2 <= 1'b0;
    end else begin
      rdy_s1 <= adc_ready;
      rdy_s2 <= rdy_s1;
    end
  end

  assign go_conv = (state == C_IDLE) && (trig || tick);

  always_comb begin
    rd_go  = 1'b0;
    to_hit = 1'b0;
    if (state == C_WAIT) begin
      if (busy_m) begin
        rd_go  = (tmr >= TW'(WAIT_MIN)) && rdy_s2;
        to_hit = !rd_go && (tmr == TW'(TIMEOUT_CYC));
      end else begin
        rd_go = (tmr == TW'(FIXED_CYC));
      end
    end
  end

  adc_pace #(.PERIOD_CYC(PERIOD_CYC)) u_pace (
    .clk     (clk),
    .rst     (rst),
    .started (go_conv),
    .run_en  (run_en),
    .tick    (tick)
  );

  adc_rd_seq #(
    .DATA_W (DATA_W),
    .RD_CYC (RD_CYC),
    .SU_CYC (SU_CYC),
    .HD_CYC (HD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (rd_go),
    .byte_mode (byte_mode),
    .bus       (adc_data),
    .cs_n      (adc_cs_n),
    .rd_n      (adc_rd_n),
    .hben      (adc_hben),
    .word      (seq_word),
    .done      (seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= C_IDLE;
      tmr          <= '0;
      busy_m       <= 1'b0;
      adc_convst   <= 1'b0;
      sample       <= '0;
      sample_valid <= 1'b0;
      timeout_err  <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      timeout_err  <= 1'b0;
      case (state)
        C_IDLE: if (go_conv) begin
          adc_convst <= 1'b1;
          busy_m     <= use_busy;
          tmr        <= TW'(1);
          state      <= C_START;
        end
        C_START: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(START_CYC)) begin
            adc_convst <= 1'b0;
            state      <= C_WAIT;
          end
        end
        C_WAIT: begin
          tmr <= tmr + 1'b1;
          if (rd_go)
            state <= C_READ;
          else if (to_hit) begin
            timeout_err <= 1'b1;
            state       <= C_IDLE;
          end
        end
        C_READ: if (seq_done) begin
          sample       <= seq_word;
          sample_valid <= 1'b1;
          state        <= C_IDLE;
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  // R2
  convst_cs_excl_chk: assert property (@(posedge clk) disable iff (rst) adc_convst |-> adc_cs_n);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) sample_valid |=> !sample_valid);
  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst) timeout_err |=> !timeout_err && !sample_valid);
  // R3
  read_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_cs_n) && busy_m) |-> $past(adc_ready, 3));
endmodule

// File: tb/adc_readout_ctrl_test.sv
`timescale 1ns/1ps
module adc_readout_ctrl_test;
  localparam int START_W  = 10;
  localparam int FIXED_W  = 1300;
  localparam int RD_W     = 12;
  localparam int SU_W     = 16;
  localparam int HD_W     = 5;
  localparam int LAT_WORD = 15;
  localparam int LAT_BYTE = 67;
  localparam int PERIOD   = 1600;
  localparam int TMO      = 2000;
  localparam int CONV_CYC = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0, run_en = 1'b0, byte_m = 1'b0, busy_m = 1'b1;
  logic adc_ready = 1'b1;
  logic [15:0] adc_data;
  logic adc_convst, adc_cs_n, adc_rd_n, adc_hben, sample_valid, timeout_err;
  logic [15:0] sample;

  always #2.5 clk = ~clk;

  adc_readout_ctrl uut (
    .clk(clk), .rst(rst), .trig(trig), .run_en(run_en),
    .byte_mode(byte_m), .use_busy(busy_m),
    .adc_ready(adc_ready), .adc_data(adc_data),
    .adc_convst(adc_convst), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_hben(adc_hben), .sample(sample), .sample_valid(sample_valid),
    .timeout_err(timeout_err)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural converter model ----------------
  logic        hang = 1'b0;
  logic        cv_prev = 1'b0;
  int          busy_left = 0;
  int          conv_idx = 0;
  int          rd_cnt = 0;
  logic [15:0] result = 16'h0000;
  logic [15:0] lfsr = 16'hB3C1;
  logic [15:0] data_q[$];

  function automatic logic [15:0] pick(input int idx, input logic [15:0] l);
    case (idx)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h00FF;
      3: return 16'hFF00;
      default: return l;
    endcase
  endfunction

  always @(posedge clk) begin
    cv_prev <= adc_convst;
    rd_cnt  <= (!adc_cs_n && !adc_rd_n) ? rd_cnt + 1 : 0;
    if (adc_convst && !cv_prev) begin
      adc_ready <= 1'b0;
      busy_left <= CONV_CYC;
    end else if (busy_left > 0) begin
      busy_left <= busy_left - 1;
      if (busy_left == 1 && !hang) begin
        logic [15:0] v;
        v = pick(conv_idx, lfsr);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        conv_idx++;
        result    <= v;
        adc_ready <= 1'b1;
        data_q.push_back(v);
      end
    end
  end

  assign adc_data = (rd_cnt >= 11) ?
                    (byte_m ? {8'hA5, (adc_hben ? result[15:8] : result[7:0])} : result) :
                    16'h5A5A;

  // ---------------- reference monitor, every clock ----------------
  int exp_valid_q[$];
  int exp_err_q[$];
  logic p_cv = 1'b0, p_cs = 1'b1, p_rd = 1'b1, p_hb = 1'b0, p_rdy = 1'b1;
  int cv_rise = 0, rdy_rise = 0, rd_fall = 0, rd_rise = -100, hb_chg = -100;
  int reads = 0, nstarts = 0, done_cnt = 0, last_start = 0;
  bit period_chk = 1'b0, have_last = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (adc_convst && !p_cv) begin
        nstarts++;
        cv_rise = cyc;
        if (busy_m && hang) exp_err_q.push_back(cyc + TMO);
        if (period_chk && have_last) chk(cyc - last_start == PERIOD, "R9 start spacing", cyc - last_start, PERIOD);
        have_last  = period_chk;
        last_start = cyc;
      end
      if (!adc_convst && p_cv) chk(cyc - cv_rise == START_W, "R2 start width", cyc - cv_rise, START_W);
      if (adc_convst) chk(adc_cs_n, "R2 cs during start", adc_cs_n, 1);
      if (adc_ready && !p_rdy) rdy_rise = cyc;
      if (!adc_cs_n && p_cs) begin
        reads = 0;
        exp_valid_q.push_back(cyc + (byte_m ? LAT_BYTE : LAT_WORD));
        if (busy_m) chk(cyc - rdy_rise == 3, "R3 read start after ready", cyc - rdy_rise, 3);
        else        chk(cyc - cv_rise == FIXED_W, "R4 fixed wait", cyc - cv_rise, FIXED_W);
      end
      if (!adc_rd_n && p_rd) begin
        reads++;
        rd_fall = cyc;
        chk(!adc_cs_n, "R5 cs low at strobe", adc_cs_n, 0);
        if (byte_m) begin
          chk(adc_hben == (reads == 1), "R6 byte order", adc_hben, reads == 1);
          chk(cyc - hb_chg >= SU_W, "R6 select setup", cyc - hb_chg, SU_W);
        end else begin
          chk(!adc_hben, "R7 select low in word mode", adc_hben, 0);
        end
      end
      if (adc_rd_n && !p_rd) begin
        rd_rise = cyc;
        chk(cyc - rd_fall == RD_W, "R5 strobe width", cyc - rd_fall, RD_W);
      end
      if (adc_hben != p_hb) begin
        hb_chg = cyc;
        if (reads > 0) chk(cyc - rd_rise >= HD_W, "R6 select hold", cyc - rd_rise, HD_W);
      end
      if (adc_cs_n && !p_cs) begin
        if (byte_m) chk(reads == 2, "R6 two reads", reads, 2);
        else        chk(reads == 1, "R7 one read", reads, 1);
      end
      // valid pulse compared against the predicted cycle
      begin
        bit ev;
        bit ee;
        ev = (exp_valid_q.size() > 0) && (exp_valid_q[0] == cyc);
        chk(sample_valid == ev, "R8 valid timing", sample_valid, ev);
        if (ev) void'(exp_valid_q.pop_front());
        if (sample_valid) begin
          done_cnt++;
          if (data_q.size() > 0) begin
            chk(sample == data_q[0], "R8 sample value", sample, data_q[0]);
            void'(data_q.pop_front());
          end else begin
            chk(1'b0, "R8 sample without conversion", sample, 0);
          end
        end
        ee = (exp_err_q.size() > 0) && (exp_err_q[0] == cyc);
        chk(timeout_err == ee, "R11 timeout flag", timeout_err, ee);
        if (ee) void'(exp_err_q.pop_front());
        if (timeout_err) done_cnt++;
      end
    end
    p_cv = adc_convst; p_cs = adc_cs_n; p_rd = adc_rd_n; p_hb = adc_hben; p_rdy = adc_ready;
  end

  // ---------------- stimulus ----------------
  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic one_conv();
    int d0;
    d0 = done_cnt;
    pulse_trig();
    while (done_cnt == d0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!adc_convst, "R1 convst", adc_convst, 0);
    chk(adc_cs_n && adc_rd_n, "R1 cs/rd idle", {adc_cs_n, adc_rd_n}, 3);
    chk(!adc_hben, "R1 hben", adc_hben, 0);
    chk(!sample_valid && !timeout_err, "R1 flags", {sample_valid, timeout_err}, 0);

    // word reads, ready-driven (R3, R7)
    byte_m = 1'b0; busy_m = 1'b1;
    one_conv(); one_conv();
    // byte reads, ready-driven (R6)
    byte_m = 1'b1;
    one_conv(); one_conv();
    // fixed wait (R4) in both read modes
    busy_m = 1'b0;
    one_conv();
    byte_m = 1'b0;
    one_conv();

    // R10: requests during a conversion are ignored
    busy_m = 1'b1;
    begin
      int s0, d0;
      s0 = nstarts; d0 = done_cnt;
      pulse_trig();
      repeat (3) @(negedge clk);
      pulse_trig();
      repeat (500) @(negedge clk);
      pulse_trig();
      while (done_cnt == d0) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(nstarts == s0 + 1, "R10 extra request ignored", nstarts, s0 + 1);
    end

    // R9 periodic starts in byte mode
    byte_m = 1'b1;
    begin
      int d0;
      d0 = done_cnt;
      period_chk = 1'b1;
      @(negedge clk) run_en = 1'b1;
      while (done_cnt < d0 + 3) @(negedge clk);
      while (adc_convst == 1'b0) @(negedge clk);
      run_en = 1'b0;
      while (done_cnt < d0 + 4) @(negedge clk);
      period_chk = 1'b0;
      repeat (1700) @(negedge clk);
      chk(done_cnt == d0 + 4, "R9 no start after disable", done_cnt, d0 + 4);
    end

    // R11 converter never finishes
    byte_m = 1'b0; busy_m = 1'b1; hang = 1'b1;
    begin
      int d0;
      d0 = done_cnt;
      pulse_trig();
      while (done_cnt == d0) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(adc_cs_n, "R11 no read after timeout", adc_cs_n, 1);
    end

    chk(data_q.size() == 0, "R8 all samples delivered", data_q.size(), 0);
    chk(exp_valid_q.size() == 0 && exp_err_q.size() == 0, "R8 no pending events",
        exp_valid_q.size() + exp_err_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual %0d expected <150000 cycles", cyc);
    summary();
    $finish;
  end
endmodule